// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block sits next to a simple processor core and takes over the control flow whenever an interrupt is serviced. Request pulses from a nonmaskable line, an internal trap input and a set of maskable lines are captured in per-source pending flags. Once a flag is eligible, the sequencer waits for the core to report an instruction boundary. It then stalls the core and writes the current program counter and status word to a downward-growing stack in memory. Next it reads the handler address from a vector table and hands the core a new program counter and status word.

A return command from the core runs the mirror sequence. The status word comes back from the stack first and the program counter second, and both are then loaded into the core. The global interrupt enable is a bit of the status word: entry clears it in the status word handed to the handler, and a return restores whatever value was saved.

The controller has eight states. `ST_IDLE` moves to `ST_PUSH_PC` on acceptance, or to `ST_POP_SR` on a return command. The entry chain runs `ST_PUSH_PC` → `ST_PUSH_SR` → `ST_VECTOR` → `ST_ENTER` → `ST_IDLE`. The return chain runs `ST_POP_SR` → `ST_POP_PC` → `ST_EXIT` → `ST_IDLE`. Every state except `ST_IDLE` lasts exactly one cycle.

Top module: `vis_irq_sequencer`

## Requirements
- R1: A single-cycle high pulse on any request input sets that source's pending flag, and the flag stays set while the source cannot be accepted, until that source is accepted.
- R2: After reset the block is idle: `stall_o`, `mem_req_o` and `pc_load_o` are low. A pending eligible source is accepted only in `ST_IDLE` in a cycle with `boundary_i` high, and `stall_o` goes high in the following cycle.
- R3: After acceptance, the captured PC is written to address SP-1 in the first cycle and the captured SR to SP-2 in the next cycle. SP then stays two words lower. SP resets to `SP_INIT`.
- R4: Source indices are 0 for the nonmaskable input, 1 for the trap input and 2+k for maskable line k. In the third cycle after acceptance, the block reads address `VEC_BASE` + index. In the fourth cycle it asserts `pc_load_o`, `sr_load_o` and `enter_o` together, with `pc_o` equal to the word read, `sr_o` equal to the saved SR with bit `IE_BIT` cleared, and `src_o` equal to the index.
- R5: A `reti_i` pulse in `ST_IDLE` reads the SR from address SP and then the PC from SP+1 in consecutive cycles. The cycle after that asserts `pc_load_o` and `sr_load_o` with those two words and `enter_o` low. SP ends two words higher.
- R6: Maskable sources are eligible only while `sr_i[IE_BIT]` is 1. With the bit at 0, a pending maskable request and a boundary cause no memory access and no stall. The nonmaskable source is eligible regardless of that bit.
- R7: The trap input is eligible regardless of `sr_i[IE_BIT]` and is serviced through the same push, vector and load sequence as an external request.
- R8: When several eligible sources are pending at a boundary, the lowest index wins: nonmaskable, then trap, then maskable line 0 upward.
- R9: Only the accepted source's pending flag is cleared, in the vector-read cycle. All other pending flags remain set.
- R10: When `reti_i` and an acceptance condition coincide in `ST_IDLE`, the return sequence runs and the pending request stays latched for a later boundary.
- R11: Requests that arrive while the block is stalling the core are latched and are accepted at the first boundary after the block returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Nonmaskable request pulse (source 0) |
| trap_i | input | 1 | Internal exception request pulse (source 1) |
| irq_i | input | NMASK | Maskable request pulses (source 2+k) |
| boundary_i | input | 1 | Core has completed an instruction this cycle |
| reti_i | input | 1 | Return-from-interrupt command |
| pc_i | input | DW | Core program counter to save |
| sr_i | input | DW | Core status word to save; bit IE_BIT is the global enable |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the same cycle as the request |
| pc_o | output | DW | Program counter to load into the core |
| pc_load_o | output | 1 | Load strobe for pc_o |
| sr_o | output | DW | Status word to load into the core |
| sr_load_o | output | 1 | Load strobe for sr_o |
| enter_o | output | 1 | Handler entry pulse |
| src_o | output | SW | Index of the source being serviced |
| stall_o | output | 1 | Core must hold while high |

## Verification
The bench builds the block with three maskable lines, so there are five sources. The vector base is 16'hFFF0, which keeps each vector read distinct from stack traffic, and the stack starts at 16'h0040. These values allow all four entries to be taken back to back from a single burst of simultaneous requests, with four levels of stacked context and a fully LIFO unwind. Masking is driven through bit 7 of the supplied status word. This makes it possible to hold a maskable request pending across an NMI entry and return and then see it serviced once the bit is set.

// File: rtl/vis_pkg.sv
package vis_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_VECTOR,
        ST_ENTER,
        ST_POP_SR,
        ST_POP_PC,
        ST_EXIT
    } seq_state_e;

    localparam int SRC_NMI   = 0;
    localparam int SRC_TRAP  = 1;
    localparam int SRC_LINE0 = 2;

endpackage

// File: rtl/vis_req_latch.sv
module vis_req_latch #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);

    // One sticky flag per source; a new pulse wins over a same-cycle clear.
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= set_i[g] | (flag_q & ~clr_i[g]);
            end
        end
        assign pend_o[g] = flag_q;
    end

endmodule

// File: rtl/vis_prio_pick.sv
module vis_prio_pick #(
    parameter int NSRC = 6,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] allow_i,
    output logic            hit_o,
    output logic [SW-1:0]   idx_o
);

    logic [NSRC-1:0] elig;
    assign elig = pend_i & allow_i;

    // Lowest index wins: scan from the top so the last match is the smallest.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit_o = 1'b1;
                idx_o = SW'(i);
            end
        end
    end

endmodule

// File: rtl/vis_stack_ptr.sv
module vis_stack_ptr #(
    parameter int          AW      = 16,
    parameter logic [AW-1:0] SP_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          inc_i,
    output logic [AW-1:0] sp_o
);

    logic [AW-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else if (dec_i) begin
            sp_q <= sp_q - AW'(1);
        end else if (inc_i) begin
            sp_q <= sp_q + AW'(1);
        end
    end

    assign sp_o = sp_q;

endmodule

// File: rtl/vis_seq_fsm.sv
module vis_seq_fsm
    import vis_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter int            NSRC     = 6,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter int            IE_BIT   = 7,
    localparam int           SW       = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_i,
    input  logic [SW-1:0]   idx_i,
    input  logic            boundary_i,
    input  logic            reti_i,
    input  logic [DW-1:0]   pc_i,
    input  logic [DW-1:0]   sr_i,
    input  logic [AW-1:0]   sp_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic            sp_dec_o,
    output logic            sp_inc_o,
    output logic [NSRC-1:0] clr_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic [DW-1:0]   pc_o,
    output logic            pc_load_o,
    output logic [DW-1:0]   sr_o,
    output logic            sr_load_o,
    output logic            enter_o,
    output logic [SW-1:0]   src_o,
    output logic            stall_o
);

    localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;

    seq_state_e    state_q, state_d;
    logic [DW-1:0] pc_sv_q;
    logic [DW-1:0] sr_sv_q;
    logic [DW-1:0] vec_q;
    logic [SW-1:0] src_q;
    logic          take_irq;
    logic          take_ret;

    // Return has precedence over acceptance in the same idle cycle.
    assign take_ret = (state_q == ST_IDLE) && reti_i;
    assign take_irq = (state_q == ST_IDLE) && !reti_i && hit_i && boundary_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Saved context and fetched vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_sv_q <= '0;
            sr_sv_q <= '0;
            vec_q   <= '0;
            src_q   <= '0;
        end else begin
            if (take_irq) begin
                pc_sv_q <= pc_i;
                sr_sv_q <= sr_i;
                src_q   <= idx_i;
            end
            if (state_q == ST_VECTOR) begin
                vec_q <= mem_rdata_i;
            end
            if (state_q == ST_POP_SR) begin
                sr_sv_q <= mem_rdata_i;
            end
            if (state_q == ST_POP_PC) begin
                pc_sv_q <= mem_rdata_i;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_ret) begin
                    state_d = ST_POP_SR;
                end else if (take_irq) begin
                    state_d = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: state_d = ST_PUSH_SR;
            ST_PUSH_SR: state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_ENTER;
            ST_ENTER:   state_d = ST_IDLE;
            ST_POP_SR:  state_d = ST_POP_PC;
            ST_POP_PC:  state_d = ST_EXIT;
            ST_EXIT:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sp_dec_o    = 1'b0;
        sp_inc_o    = 1'b0;
        clr_o       = '0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        pc_o        = '0;
        pc_load_o   = 1'b0;
        sr_o        = '0;
        sr_load_o   = 1'b0;
        enter_o     = 1'b0;
        stall_o     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PUSH_PC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_i - AW'(1);
                mem_wdata_o = pc_sv_q;
                sp_dec_o    = 1'b1;
            end
            ST_PUSH_SR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_i - AW'(1);
                mem_wdata_o = sr_sv_q;
                sp_dec_o    = 1'b1;
            end
            ST_VECTOR: begin
                mem_req_o     = 1'b1;
                mem_addr_o    = VEC_BASE + AW'(src_q);
                clr_o[src_q]  = 1'b1;
            end
            ST_ENTER: begin
                pc_o      = vec_q;
                sr_o      = sr_sv_q & ~IE_MASK;
                pc_load_o = 1'b1;
                sr_load_o = 1'b1;
                enter_o   = 1'b1;
            end
            ST_POP_SR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_i;
                sp_inc_o   = 1'b1;
            end
            ST_POP_PC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_i;
                sp_inc_o   = 1'b1;
            end
            ST_EXIT: begin
                pc_o      = pc_sv_q;
                sr_o      = sr_sv_q;
                pc_load_o = 1'b1;
                sr_load_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign src_o = src_q;

endmodule

// File: rtl/vis_irq_sequencer.sv
module vis_irq_sequencer
    import vis_pkg::*;
#(
    parameter int            NMASK    = 4,
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter logic [AW-1:0] VEC_BASE = '1 << 4,
    parameter logic [AW-1:0] SP_INIT  = AW'(16'h0100),
    parameter int            IE_BIT   = 7,
    localparam int           NSRC     = NMASK + 2,
    localparam int           SW       = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_i,
    input  logic             trap_i,
    input  logic [NMASK-1:0] irq_i,
    input  logic             boundary_i,
    input  logic             reti_i,
    input  logic [DW-1:0]    pc_i,
    input  logic [DW-1:0]    sr_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic [DW-1:0]    pc_o,
    output logic             pc_load_o,
    output logic [DW-1:0]    sr_o,
    output logic             sr_load_o,
    output logic             enter_o,
    output logic [SW-1:0]    src_o,
    output logic             stall_o
);

    logic [NSRC-1:0] req_set;
    logic [NSRC-1:0] req_clr;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] allow;
    logic            hit;
    logic [SW-1:0]   idx;
    logic [AW-1:0]   sp;
    logic            sp_dec;
    logic            sp_inc;

    // Source order fixes priority: nonmaskable, trap, then maskable lines.
    assign req_set = {irq_i, trap_i, nmi_i};
    assign allow   = {{NMASK{sr_i[IE_BIT]}}, 1'b1, 1'b1};

    vis_req_latch #(.NSRC(NSRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_set),
        .clr_i  (req_clr),
        .pend_o (pend)
    );

    vis_prio_pick #(.NSRC(NSRC)) u_pick (
        .pend_i  (pend),
        .allow_i (allow),
        .hit_o   (hit),
        .idx_o   (idx)
    );

    vis_stack_ptr #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_i (sp_dec),
        .inc_i (sp_inc),
        .sp_o  (sp)
    );

    vis_seq_fsm #(
        .AW       (AW),
        .DW       (DW),
        .NSRC     (NSRC),
        .VEC_BASE (VEC_BASE),
        .IE_BIT   (IE_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .idx_i       (idx),
        .boundary_i  (boundary_i),
        .reti_i      (reti_i),
        .pc_i        (pc_i),
        .sr_i        (sr_i),
        .sp_i        (sp),
        .mem_rdata_i (mem_rdata_i),
        .sp_dec_o    (sp_dec),
        .sp_inc_o    (sp_inc),
        .clr_o       (req_clr),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .pc_o        (pc_o),
        .pc_load_o   (pc_load_o),
        .sr_o        (sr_o),
        .sr_load_o   (sr_load_o),
        .enter_o     (enter_o),
        .src_o       (src_o),
        .stall_o     (stall_o)
    );

endmodule

// File: rtl/vis_irq_checker.sv
module vis_irq_checker #(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter int            IE_BIT   = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boundary_i,
    input logic          reti_i,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          pc_load_o,
    input logic          sr_load_o,
    input logic [DW-1:0] sr_o,
    input logic          enter_o,
    input logic          stall_o
);

    // R2: the core is only stalled after a boundary or a return command
    p_accept_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(boundary_i || reti_i));

    // R3: the first push is followed by a second push one word lower
    p_push_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !$past(mem_req_o && mem_we_o)) |=>
        (mem_req_o && mem_we_o && mem_addr_o == $past(mem_addr_o) - AW'(1)));

    // R4: two pushes are followed by a read inside the vector table
    p_vector_after_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o)) |=>
        (mem_req_o && !mem_we_o && mem_addr_o >= VEC_BASE));

    // R4: entry loads both registers with the enable bit cleared
    p_entry_clears_ie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |-> (pc_load_o && sr_load_o && !sr_o[IE_BIT]));

    // R5: the first pop is followed by a second pop one word higher
    p_pop_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && !$past(mem_req_o)) |=>
        (mem_req_o && !mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(1)));

    // R5: register loads only happen while the core is held
    p_load_while_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> stall_o);

endmodule

bind vis_irq_sequencer vis_irq_checker #(
    .AW       (AW),
    .DW       (DW),
    .VEC_BASE (VEC_BASE),
    .IE_BIT   (IE_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .reti_i     (reti_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .pc_load_o  (pc_load_o),
    .sr_load_o  (sr_load_o),
    .sr_o       (sr_o),
    .enter_o    (enter_o),
    .stall_o    (stall_o)
);

// File: tb/vis_irq_sequencer_test.sv
`timescale 1ns/1ps
module vis_irq_sequencer_test;

    localparam int            NMASK = 3;
    localparam logic [15:0]   VB    = 16'hFFF0;
    localparam logic [15:0]   SPI   = 16'h0040;
    localparam logic [15:0]   IEM   = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 1'b0, trap = 1'b0, bnd = 1'b0, reti = 1'b0;
    logic [2:0]  irq = '0;
    logic [15:0] pc_in = '0, sr_in = '0;
    logic        mem_req, mem_we, pc_load, sr_load, enter, stall;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out, sr_out;
    logic [2:0]  src;

    always #2 clk = ~clk;

    vis_irq_sequencer #(
        .NMASK(NMASK), .AW(16), .DW(16), .VEC_BASE(VB), .SP_INIT(SPI), .IE_BIT(7)
    ) uut (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .trap_i(trap), .irq_i(irq),
        .boundary_i(bnd), .reti_i(reti), .pc_i(pc_in), .sr_i(sr_in),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .pc_o(pc_out), .pc_load_o(pc_load), .sr_o(sr_out), .sr_load_o(sr_load),
        .enter_o(enter), .src_o(src), .stall_o(stall)
    );

    // Memory model: small stack RAM plus a computed vector table
    logic [15:0] ram [0:255];
    function automatic logic [15:0] vec_val(int s);
        return 16'h4000 + 16'(s << 8);
    endfunction
    assign mem_rdata = (mem_addr >= VB) ? vec_val(int'(mem_addr - VB)) : ram[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_we) ram[mem_addr[7:0]] <= mem_wdata;

    // Scoreboard
    typedef struct {
        int          kind;   // 0 write, 1 read, 2 register load
        logic [15:0] addr;
        logic [15:0] d0;
        logic [15:0] d1;
        int          src;    // -1 for a return load
        string       tag;
    } exp_t;
    exp_t        q[$];
    logic [15:0] shadow_pc[$];
    logic [15:0] shadow_sr[$];
    logic [15:0] sp_m = SPI;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    task automatic push_exp(int k, logic [15:0] a, logic [15:0] x, logic [15:0] y, int s, string t);
        exp_t e;
        e.kind = k; e.addr = a; e.d0 = x; e.d1 = y; e.src = s; e.tag = t;
        q.push_back(e);
    endtask

    task automatic expect_entry(int s, string t);
        push_exp(0, sp_m - 16'd1, pc_in, 16'h0, -1, {t, " R3 pc push"});
        push_exp(0, sp_m - 16'd2, sr_in, 16'h0, -1, {t, " R3 sr push"});
        push_exp(1, VB + 16'(s), 16'h0, 16'h0, -1, {t, " R4 vector read"});
        push_exp(2, 16'h0, vec_val(s), sr_in & ~IEM, s, {t, " R4 entry load"});
        shadow_pc.push_back(pc_in);
        shadow_sr.push_back(sr_in);
        sp_m = sp_m - 16'd2;
    endtask

    task automatic expect_return(string t);
        logic [15:0] p, r;
        p = shadow_pc.pop_back();
        r = shadow_sr.pop_back();
        push_exp(1, sp_m, 16'h0, 16'h0, -1, {t, " R5 sr pop"});
        push_exp(1, sp_m + 16'd1, 16'h0, 16'h0, -1, {t, " R5 pc pop"});
        push_exp(2, 16'h0, p, r, -1, {t, " R5 exit load"});
        sp_m = sp_m + 16'd2;
    endtask

    task automatic check_op(int k, logic [15:0] a, logic [15:0] x, logic [15:0] y, int s);
        exp_t e;
        bit   bad;
        n_chk++;
        if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R2/R6 unexpected activity: actual kind %0d addr %h data %h, expected none", k, a, x);
            return;
        end
        e = q.pop_front();
        bad = (k != e.kind);
        if (e.kind != 2 && a != e.addr) bad = 1'b1;
        if (e.kind != 1 && x != e.d0) bad = 1'b1;
        if (e.kind == 2 && (y != e.d1 || s != e.src)) bad = 1'b1;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: actual kind %0d addr %h d0 %h d1 %h src %0d, expected kind %0d addr %h d0 %h d1 %h src %0d",
                     e.tag, k, a, x, y, s, e.kind, e.addr, e.d0, e.d1, e.src);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_req) check_op(mem_we ? 0 : 1, mem_addr, mem_wdata, 16'h0, -1);
            if (pc_load) check_op(2, 16'h0, pc_out, sr_out, enter ? int'(src) : -1);
        end
    end

    task automatic check(bit ok, string t, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d, expected %0d", t, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(int s);
        if (s == 0) nmi = 1'b1; else if (s == 1) trap = 1'b1; else irq[s-2] = 1'b1;
        tick(1);
        nmi = 1'b0; trap = 1'b0; irq = '0;
    endtask

    task automatic boundary_pulse();
        bnd = 1'b1;
        tick(1);
        bnd = 1'b0;
    endtask

    task automatic wait_idle(string t);
        int guard = 0;
        while (stall && guard < 20) begin
            tick(1);
            guard++;
        end
        tick(1);
        check(q.size() == 0, {t, " sequence complete"}, q.size(), 0);
    endtask

    task automatic do_return(string t);
        expect_return(t);
        reti = 1'b1;
        tick(1);
        reti = 1'b0;
        wait_idle(t);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(!stall && !mem_req && !pc_load, "R2 idle after reset", int'(stall), 0);

        // R2/R3/R4: maskable line 1 (index 3) waits for a boundary
        sr_in = 16'h0081; pc_in = 16'h1234;
        pulse_src(3);
        tick(4);
        check(!stall, "R2 no acceptance without boundary", int'(stall), 0);
        expect_entry(3, "A");
        boundary_pulse();
        check(stall, "R2 stall after boundary", int'(stall), 1);
        wait_idle("A");
        do_return("A");

        // R6: masked line stays latched; NMI passes regardless
        sr_in = 16'h0005; pc_in = 16'h2222;
        pulse_src(2);
        boundary_pulse();
        tick(3);
        check(!stall, "R6 masked request ignored", int'(stall), 0);
        pulse_src(0);
        expect_entry(0, "B nmi R6");
        boundary_pulse();
        wait_idle("B");
        do_return("B");
        // R1: the earlier pulse is still pending once enabled
        sr_in = 16'h0085; pc_in = 16'h3333;
        expect_entry(2, "B held R1");
        boundary_pulse();
        wait_idle("B held R1");
        do_return("B held R1");

        // R7: trap with the enable bit clear
        sr_in = 16'h0001; pc_in = 16'h4444;
        pulse_src(1);
        expect_entry(1, "C trap R7");
        boundary_pulse();
        wait_idle("C R7");
        do_return("C R7");

        // R8/R9: simultaneous requests, taken in priority order, nested
        sr_in = 16'h0080;
        nmi = 1'b1; trap = 1'b1; irq = 3'b101;
        tick(1);
        nmi = 1'b0; trap = 1'b0; irq = '0;
        begin
            int order [4] = '{0, 1, 2, 4};
            foreach (order[i]) begin
                pc_in = 16'h5000 + 16'(i);
                expect_entry(order[i], "D R8 R9");
                boundary_pulse();
                wait_idle("D R8 R9");
            end
        end
        for (int i = 0; i < 4; i++) do_return("D LIFO R5");

        // R11: request during sequencing is latched and taken afterwards
        sr_in = 16'h0080; pc_in = 16'h6000;
        pulse_src(0);
        expect_entry(0, "E first");
        boundary_pulse();
        pulse_src(3);
        wait_idle("E first");
        pc_in = 16'h6100;
        expect_entry(3, "E R11");
        boundary_pulse();
        wait_idle("E R11");

        // R10: return wins over a coincident acceptance
        pulse_src(2);
        expect_return("F R10");
        bnd = 1'b1; reti = 1'b1;
        tick(1);
        bnd = 1'b0; reti = 1'b0;
        wait_idle("F R10");
        pc_in = 16'h6200;
        expect_entry(2, "F R10 later");
        boundary_pulse();
        wait_idle("F R10 later");
        do_return("F");
        do_return("E");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule